// File: doc/BRIEF.md
# USB OUT Endpoint Two-Packet Receive Buffer

This block is the receive-side store for one USB device OUT endpoint. Bytes come in from the serial engine with a write strobe. An end-of-packet strobe closes each packet. The store holds 256 bytes, split into two slots of 128 bytes. Each slot holds one complete packet. When an OUT token arrives, the block answers ACK if a slot is free and NAK if both slots hold complete packets. It keeps answering NAK until draining frees a whole slot.

The drain side pops one byte per strobe from a 32-bit read-data port. Software or a DMA engine can drive the pop strobe. The read port always shows the head byte of the oldest complete packet. While a complete packet is waiting, the block raises an interrupt request, or a DMA request when DMA mode is selected.

Receive states: `RX_IDLE` waits for a token. An accepted token (transition *accept*) moves to `RX_FILL`. A refused token (transition *refuse*) moves to `RX_SKIP`. Either state returns to `RX_IDLE` on end-of-packet (transition *close*). Occupancy states: `OCC_NONE`, `OCC_ONE` and `OCC_TWO`. A *commit* moves one state up. A *release*, which is the pop of a packet's last byte, moves one state down. When both happen on the same edge, the state holds.

Top module: `usb_out_pktbuf`

## Requirements
- R1: After reset, rd_data is zero, irq, dma_req, ovf, hs_ack and hs_nak are low, and no packet is held.
- R2: An OUT token seen in RX_IDLE while fewer than two complete packets are held produces a one-cycle hs_ack in the next cycle. The bytes that follow are stored as a new packet.
- R3: An OUT token seen in RX_IDLE while two complete packets are held produces a one-cycle hs_nak in the next cycle, and that packet's bytes are dropped. Tokens keep getting NAK until the last byte of a held packet is popped.
- R4: rd_data[7:0] is the head byte of the oldest complete packet and rd_data[31:8] is always zero. Packets drain in the order they completed.
- R5: A pop while a complete packet is held advances one byte. The pop of a packet's last byte frees its slot on that edge, and from the next cycle rd_data shows the first byte of the other packet, if one is held.
- R6: A pop while no complete packet is held leaves rd_data at zero and moves no pointer.
- R7: irq is high exactly while a complete packet is held and dma_mode is 0. dma_req is high exactly while a complete packet is held and dma_mode is 1.
- R8: Bytes after the 128th of a packet are dropped, the packet keeps length 128, and ovf is set. A high ovf_clr clears ovf unless an overflow occurs in the same cycle.
- R9: A packet that closes with no data byte is acknowledged but not stored.
- R10: Tokens that arrive during RX_FILL or RX_SKIP get no handshake. Data strobes in RX_IDLE are ignored.
- R11: An end-of-packet commit and a last-byte pop on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_token | input | 1 | OUT token addressed to this endpoint (one cycle) |
| rx_wr | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End of packet; a byte strobed in the same cycle belongs to the packet |
| hs_ack | output | 1 | ACK decision pulse |
| hs_nak | output | 1 | NAK decision pulse |
| dma_mode | input | 1 | 1 selects the DMA request, 0 the interrupt |
| rd_pop | input | 1 | Pop the head byte |
| rd_data | output | 32 | Head byte in bits 7:0, zero above |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| ovf | output | 1 | Overflow status |
| ovf_clr | input | 1 | Clear overflow status |

## Verification
Two events can land on the same edge: the end-of-packet commit of a new packet and the pop of the last byte of the packet being drained. The bench provokes this by running a receive and a drain sequence in parallel, timed so that the final pop and the end-of-packet strobe share a cycle. It then checks that the request stays high and that rd_data moves straight to the new packet's first byte. The same overlap arises when a token meets a full buffer on the edge where a slot frees. The decision must follow the pre-edge occupancy, and the cycle-by-cycle reference model judges both cases.

// File: rtl/usbob_pkg.sv
package usbob_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/usbob_rx_fsm.sv
module usbob_rx_fsm
    import usbob_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    parameter int AW         = $clog2(SLOT_BYTES),
    parameter int LEN_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_token,
    input  logic             rx_wr,
    input  logic             rx_eop,
    input  logic             room,
    output logic             hs_ack,
    output logic             hs_nak,
    output logic             mem_we,
    output logic [AW-1:0]    wr_off,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len,
    output logic             ovf_set,
    output rx_state_t        state
);
    localparam logic [LEN_W-1:0] MAX_CNT = LEN_W'(SLOT_BYTES);

    rx_state_t        nxt;
    logic [LEN_W-1:0] wcnt;
    logic             byte_in;
    logic             ack_d;
    logic             nak_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        ack_d      = 1'b0;
        nak_d      = 1'b0;
        mem_we     = 1'b0;
        byte_in    = 1'b0;
        ovf_set    = 1'b0;
        commit     = 1'b0;
        commit_len = wcnt;
        unique case (state)
            RX_IDLE: begin
                if (out_token) begin
                    if (room) begin
                        nxt   = RX_FILL;
                        ack_d = 1'b1;
                    end else begin
                        nxt   = RX_SKIP;
                        nak_d = 1'b1;
                    end
                end
            end
            RX_FILL: begin
                if (rx_wr) begin
                    if (wcnt < MAX_CNT) begin
                        mem_we  = 1'b1;
                        byte_in = 1'b1;
                    end else begin
                        ovf_set = 1'b1;
                    end
                end
                commit_len = wcnt + LEN_W'(byte_in);
                if (rx_eop) begin
                    nxt    = RX_IDLE;
                    commit = (commit_len != '0);
                end
            end
            RX_SKIP: begin
                if (rx_eop) nxt = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt   <= '0;
            hs_ack <= 1'b0;
            hs_nak <= 1'b0;
        end else begin
            hs_ack <= ack_d;
            hs_nak <= nak_d;
            if (state != RX_FILL || rx_eop) wcnt <= '0;
            else if (byte_in)               wcnt <= wcnt + LEN_W'(1);
        end
    end

    assign wr_off = wcnt[AW-1:0];
endmodule

// File: rtl/usbob_store.sv
module usbob_store #(
    parameter int SLOT_BYTES = 128,
    parameter int AW         = $clog2(SLOT_BYTES),
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW:0]       waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW:0]       raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 * SLOT_BYTES;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/usbob_slot_trk.sv
module usbob_slot_trk
    import usbob_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    parameter int AW         = $clog2(SLOT_BYTES),
    parameter int LEN_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             pop,
    output logic             room,
    output logic             avail,
    output logic             wr_slot,
    output logic [AW:0]      rd_addr,
    output occ_state_t       occ
);
    occ_state_t       occ_nxt;
    logic             rd_slot;
    logic [LEN_W-1:0] rcnt;
    logic [LEN_W-1:0] len_q [2];
    logic             pop_ok;
    logic             release_s;

    assign avail     = (occ != OCC_NONE);
    assign room      = (occ != OCC_TWO);
    assign pop_ok    = pop && avail;
    assign release_s = pop_ok && (rcnt == len_q[rd_slot] - LEN_W'(1));
    assign rd_addr   = {rd_slot, rcnt[AW-1:0]};

    // occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= OCC_NONE;
        else        occ <= occ_nxt;
    end

    // occupancy transitions: commit moves up, release moves down
    always_comb begin
        occ_nxt = occ;
        unique case (occ)
            OCC_NONE: if (commit) occ_nxt = OCC_ONE;
            OCC_ONE: begin
                if (commit && !release_s)      occ_nxt = OCC_TWO;
                else if (!commit && release_s) occ_nxt = OCC_NONE;
            end
            OCC_TWO: if (release_s) occ_nxt = OCC_ONE;
            default: occ_nxt = OCC_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= 1'b0;
            wr_slot <= 1'b0;
            rcnt    <= '0;
            for (int s = 0; s < 2; s++) len_q[s] <= '0;
        end else begin
            if (release_s)   rcnt <= '0;
            else if (pop_ok) rcnt <= rcnt + LEN_W'(1);
            if (release_s) rd_slot <= ~rd_slot;
            if (commit) begin
                len_q[wr_slot] <= commit_len;
                wr_slot        <= ~wr_slot;
            end
        end
    end
endmodule

// File: rtl/usb_out_pktbuf.sv
module usb_out_pktbuf
    import usbob_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int RD_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_token,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eop,
    output logic              hs_ack,
    output logic              hs_nak,
    input  logic              dma_mode,
    input  logic              rd_pop,
    output logic [RD_W-1:0]   rd_data,
    output logic              irq,
    output logic              dma_req,
    output logic              ovf,
    input  logic              ovf_clr
);
    localparam int AW    = $clog2(SLOT_BYTES);
    localparam int LEN_W = $clog2(SLOT_BYTES + 1);

    rx_state_t         rx_st;
    occ_state_t        occ_st;
    logic              room;
    logic              avail;
    logic              mem_we;
    logic [AW-1:0]     wr_off;
    logic              commit;
    logic [LEN_W-1:0]  commit_len;
    logic              ovf_set;
    logic              wr_slot;
    logic [AW:0]       rd_addr;
    logic [DATA_W-1:0] mem_rd;

    usbob_rx_fsm #(.SLOT_BYTES(SLOT_BYTES), .AW(AW), .LEN_W(LEN_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_token  (out_token),
        .rx_wr      (rx_wr),
        .rx_eop     (rx_eop),
        .room       (room),
        .hs_ack     (hs_ack),
        .hs_nak     (hs_nak),
        .mem_we     (mem_we),
        .wr_off     (wr_off),
        .commit     (commit),
        .commit_len (commit_len),
        .ovf_set    (ovf_set),
        .state      (rx_st)
    );

    usbob_store #(.SLOT_BYTES(SLOT_BYTES), .AW(AW), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({wr_slot, wr_off}),
        .wdata (rx_data),
        .raddr (rd_addr),
        .rdata (mem_rd)
    );

    usbob_slot_trk #(.SLOT_BYTES(SLOT_BYTES), .AW(AW), .LEN_W(LEN_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_len (commit_len),
        .pop        (rd_pop),
        .room       (room),
        .avail      (avail),
        .wr_slot    (wr_slot),
        .rd_addr    (rd_addr),
        .occ        (occ_st)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    assign rd_data = RD_W'(avail ? mem_rd : '0);
    assign irq     = avail && !dma_mode;
    assign dma_req = avail && dma_mode;
endmodule

// File: rtl/usbob_chk.sv
module usbob_chk
    import usbob_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        out_token,
    input logic        rx_wr,
    input logic        hs_ack,
    input logic        hs_nak,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic        dma_req,
    input logic        ovf,
    input rx_state_t   rx_st,
    input occ_state_t  occ_st
);
    // R2
    ack_on_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_token && rx_st == RX_IDLE && occ_st != OCC_TWO) |=> (hs_ack && !hs_nak));

    // R3
    nak_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_token && rx_st == RX_IDLE && occ_st == OCC_TWO) |=> (hs_nak && !hs_ack));

    // R10
    busy_token_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_st != RX_IDLE) |=> (!hs_ack && !hs_nak));

    // R4
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:8] == 24'd0);

    // R7
    req_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    // R5
    release_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_st == OCC_TWO) |=> (occ_st != OCC_NONE));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(rx_wr));
endmodule

bind usb_out_pktbuf usbob_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_token (out_token),
    .rx_wr     (rx_wr),
    .hs_ack    (hs_ack),
    .hs_nak    (hs_nak),
    .rd_data   (rd_data),
    .irq       (irq),
    .dma_req   (dma_req),
    .ovf       (ovf),
    .rx_st     (rx_st),
    .occ_st    (occ_st)
);

// File: tb/tb_usb_out_pktbuf.sv
module tb_usb_out_pktbuf;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        out_token, rx_wr, rx_eop, dma_mode, rd_pop, ovf_clr;
    logic [7:0]  rx_data;
    logic        hs_ack, hs_nak, irq, dma_req, ovf;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    usb_out_pktbuf dut (
        .clk(clk), .rst_n(rst_n), .out_token(out_token), .rx_wr(rx_wr),
        .rx_data(rx_data), .rx_eop(rx_eop), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .dma_mode(dma_mode), .rd_pop(rd_pop), .rd_data(rd_data), .irq(irq),
        .dma_req(dma_req), .ovf(ovf), .ovf_clr(ovf_clr)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: queue of completed bytes and packet lengths
    logic [7:0] q_data[$];
    int         q_len[$];
    logic [7:0] cur[$];
    int         mst;
    logic       e_ack, e_nak, e_ovf, has_room, has_pkt, oset;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_data.delete(); q_len.delete(); cur.delete();
            mst = 0; e_ack = 0; e_nak = 0; e_ovf = 0;
        end else begin
            has_room = (q_len.size() < 2);
            has_pkt  = (q_len.size() > 0);
            e_ack = 0; e_nak = 0; oset = 0;
            if (rd_pop && has_pkt) begin
                void'(q_data.pop_front());
                q_len[0] = q_len[0] - 1;
                if (q_len[0] == 0) void'(q_len.pop_front());
            end
            case (mst)
                0: if (out_token) begin
                    if (has_room) begin mst = 1; e_ack = 1; cur.delete(); end
                    else begin mst = 2; e_nak = 1; end
                end
                1: begin
                    if (rx_wr) begin
                        if (cur.size() < 128) cur.push_back(rx_data);
                        else oset = 1;
                    end
                    if (rx_eop) begin
                        if (cur.size() > 0) begin
                            foreach (cur[i]) q_data.push_back(cur[i]);
                            q_len.push_back(cur.size());
                        end
                        mst = 0;
                    end
                end
                default: if (rx_eop) mst = 0;
            endcase
            if (oset) e_ovf = 1;
            else if (ovf_clr) e_ovf = 0;
        end
        #5;
        if (rst_n) begin
            chk("R2 hs_ack", hs_ack, e_ack);
            chk("R3 hs_nak", hs_nak, e_nak);
            chk("R4 rd_data", rd_data, q_len.size() > 0 ? {24'd0, q_data[0]} : 32'd0);
            chk("R7 irq", irq, q_len.size() > 0 && !dma_mode);
            chk("R7 dma_req", dma_req, q_len.size() > 0 && dma_mode);
            chk("R8 ovf", ovf, e_ovf);
        end
    end

    task automatic send_pkt(int n, logic [7:0] base, output logic a, output logic k);
        @(negedge clk) out_token = 1;
        @(negedge clk) out_token = 0;
        a = hs_ack; k = hs_nak;
        if (n == 0) begin
            rx_eop = 1;
            @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) begin
                rx_wr = 1; rx_data = base + 8'(i); rx_eop = (i == n - 1);
                @(negedge clk);
            end
        end
        rx_wr = 0; rx_eop = 0;
    endtask

    task automatic pop_n(int n);
        @(negedge clk) rd_pop = 1;
        repeat (n) @(negedge clk);
        rd_pop = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic a, k;
        rst_n = 0; out_token = 0; rx_wr = 0; rx_eop = 0; rx_data = 0;
        dma_mode = 0; rd_pop = 0; ovf_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", irq, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 hs", {hs_ack, hs_nak}, 0);

        send_pkt(5, 8'h10, a, k);
        chk("R2 ack", a, 1);
        chk("R4 head", rd_data, 32'h10);
        pop_n(5);
        chk("R5 empty after drain", irq, 0);

        pop_n(2);
        chk("R6 empty pop", rd_data, 0);
        send_pkt(3, 8'h40, a, k);
        chk("R6 pointers kept", rd_data, 32'h40);
        pop_n(3);

        send_pkt(4, 8'h50, a, k);
        send_pkt(6, 8'h60, a, k);
        send_pkt(2, 8'hA0, a, k);
        chk("R3 nak full", k, 1);
        pop_n(3);
        send_pkt(2, 8'hA8, a, k);
        chk("R3 nak while draining", k, 1);
        pop_n(1);
        chk("R5 next head", rd_data, 32'h60);
        send_pkt(2, 8'hB0, a, k);
        chk("R3 ack after free", a, 1);
        pop_n(8);

        dma_mode = 1;
        send_pkt(2, 8'hC0, a, k);
        chk("R7 dma_req", dma_req, 1);
        chk("R7 irq off", irq, 0);
        pop_n(2);
        dma_mode = 0;

        send_pkt(130, 8'h00, a, k);
        chk("R8 ovf set", ovf, 1);
        pop_n(127);
        chk("R8 last kept", rd_data, 32'h7F);
        pop_n(1);
        chk("R8 length 128", irq, 0);
        @(negedge clk) ovf_clr = 1;
        @(negedge clk) ovf_clr = 0;
        chk("R8 ovf clear", ovf, 0);

        send_pkt(0, 8'h00, a, k);
        chk("R9 zlp ack", a, 1);
        chk("R9 zlp not stored", irq, 0);

        @(negedge clk) out_token = 1;
        @(negedge clk) out_token = 0; rx_wr = 1; rx_data = 8'h21;
        @(negedge clk) out_token = 1; rx_data = 8'h22;
        @(negedge clk) out_token = 0; rx_data = 8'h23; rx_eop = 1;
        chk("R10 busy token", {hs_ack, hs_nak}, 0);
        @(negedge clk) rx_eop = 0; rx_data = 8'h99;
        @(negedge clk) rx_wr = 0;
        chk("R10 idle bytes", rd_data, 32'h21);
        pop_n(3);
        chk("R10 packet length", irq, 0);

        send_pkt(3, 8'h70, a, k);
        fork
            send_pkt(4, 8'h80, a, k);
            begin
                repeat (3) @(negedge clk);
                rd_pop = 1;
                repeat (3) @(negedge clk);
                rd_pop = 0;
            end
        join
        chk("R11 irq kept", irq, 1);
        chk("R11 new head", rd_data, 32'h80);
        pop_n(4);
        chk("R11 drained", irq, 0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule